// File: doc/BRIEF.md
# Ethernet Receive Frame Screen

The block sits on a byte-wide receive stream that has already lost its preamble and start delimiter. It also sits in front of a receive FIFO. Each accepted byte is counted from the destination address through the FCS. A CRC-32 is run over it, and the byte is forwarded downstream, either one cycle later or through a four-byte delay line when the FCS is to be removed. When the final byte arrives, the frame is classified. It may be good, or it may carry one or more faults: a CRC or line error, a misaligned bit count, a short or long length, or a FIFO overflow. It may also be a MAC control frame. A one-cycle done strobe then reports whether the FIFO should keep or discard the frame.

Six sticky status flags record the outcome of each frame. Each flag is masked by its own enable into a single interrupt line and is cleared by a write-one pulse. The control bits are plain inputs and are expected to stay stable while a frame is in progress. A halt request takes effect only between frames. While the halt is in effect, incoming bytes are ignored entirely.

Top module: `eth_rx_screen`

## Requirements
- R1: With `cfg_strip_fcs` low, every accepted byte appears on `out_byte` with `out_vld` one cycle later, in order. `out_last` marks the final byte of the frame.
- R2: With `cfg_strip_fcs` high, the last four bytes of a frame are never forwarded, and `out_last` marks the last byte before them. The CRC is still checked.
- R3: The CRC is CRC-32, bit-reflected, with polynomial 0xEDB88320 and initial value all ones. Computed over all bytes including the FCS, it must leave the residue 0xDEBB20E3. A mismatch sets flag bit 4 and rejects the frame. `in_err` high on any byte of the frame does the same. `cfg_skip_crc` suppresses only the mismatch test.
- R4: A CRC mismatch on a frame whose last byte has `in_odd_bits` high also sets flag bit 5. With a good CRC, `in_odd_bits` has no effect.
- R5: A frame shorter than 64 bytes sets flag bit 1 and is rejected, unless `cfg_allow_short` is high.
- R6: The length limit is 1518 bytes, or 1522 when bytes 12 and 13 (0-based) read 0x81, 0x00. A longer frame is rejected and sets flag bit 2, unless `cfg_allow_long` is high. In that case the frame is accepted and bit 2 stays clear.
- R7: `cfg_skip_len` disables both length checks.
- R8: A frame with 0x88, 0x08 at bytes 12 and 13 is a control frame. It is rejected without setting any flag unless `cfg_keep_ctl` is high.
- R9: `fifo_full` high on any accepted byte of a frame sets flag bit 3 and rejects the frame.
- R10: An accepted frame sets flag bit 0.
- R11: `out_done` pulses once, one cycle after the last byte. `out_ok` gives the verdict in that same cycle.
- R12: Flags stay set until cleared by a one on the matching `irq_clr` bit. A new event wins over a clear in the same cycle. `irq` is the OR of flags ANDed with `irq_en`.
- R13: While idle, `rx_halted` follows `cfg_halt` one cycle later. A frame already in progress completes normally. While halted, arriving bytes produce no output and no flags.
- R14: After reset, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| in_vld | input | 1 | Receive byte valid |
| in_byte | input | 8 | Receive byte |
| in_last | input | 1 | Final byte of frame |
| in_err | input | 1 | PHY receive error |
| in_odd_bits | input | 1 | Bit count not a multiple of 8 (with in_last) |
| fifo_full | input | 1 | Downstream FIFO full |
| cfg_strip_fcs | input | 1 | Withhold FCS bytes |
| cfg_skip_crc | input | 1 | Skip CRC compare |
| cfg_skip_len | input | 1 | Skip length checks |
| cfg_keep_ctl | input | 1 | Pass control frames |
| cfg_allow_short | input | 1 | Accept short frames |
| cfg_allow_long | input | 1 | Accept long frames |
| cfg_halt | input | 1 | Halt request |
| irq_en | input | 6 | Per-flag interrupt enables |
| irq_clr | input | 6 | Write-one flag clear |
| out_vld | output | 1 | Forwarded byte valid |
| out_byte | output | 8 | Forwarded byte |
| out_last | output | 1 | Last forwarded byte |
| out_done | output | 1 | Frame verdict strobe |
| out_ok | output | 1 | Keep frame |
| irq_flags | output | 6 | Sticky status flags |
| irq | output | 1 | Masked interrupt |
| rx_halted | output | 1 | Halt in effect |

## Verification
A stale CRC register, byte counter or type latch from a previous frame shows up at the very next `out_done`, as a wrong `out_ok` or a wrong flag pattern. Frames are therefore sent back to back, with mixed lengths and types. A misplaced delay-line tap corrupts `out_byte` within four bytes of the start of a frame, and every forwarded byte is compared. A halt latch that changes mid-frame shows up either as a done strobe that never comes or as bytes leaking out while `rx_halted` is high.

// File: rtl/eth_rx_screen.sv
module eth_rx_screen #(
  parameter int MIN_LEN   = 64,
  parameter int MAX_LEN   = 1518,
  parameter int TAG_EXTRA = 4,
  parameter int CNT_W     = 12
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_vld,
  input  logic [7:0] in_byte,
  input  logic       in_last,
  input  logic       in_err,
  input  logic       in_odd_bits,
  input  logic       fifo_full,
  input  logic       cfg_strip_fcs,
  input  logic       cfg_skip_crc,
  input  logic       cfg_skip_len,
  input  logic       cfg_keep_ctl,
  input  logic       cfg_allow_short,
  input  logic       cfg_allow_long,
  input  logic       cfg_halt,
  input  logic [5:0] irq_en,
  input  logic [5:0] irq_clr,
  output logic       out_vld,
  output logic [7:0] out_byte,
  output logic       out_last,
  output logic       out_done,
  output logic       out_ok,
  output logic [5:0] irq_flags,
  output logic       irq,
  output logic       rx_halted
);
  localparam logic [31:0]    POLY    = 32'hEDB88320;
  localparam logic [31:0]    RESIDUE = 32'hDEBB20E3;
  localparam logic [CNT_W:0] LIM_MIN = (CNT_W+1)'(MIN_LEN);
  localparam logic [CNT_W:0] LIM_MAX = (CNT_W+1)'(MAX_LEN);
  localparam logic [CNT_W:0] LIM_TAG = (CNT_W+1)'(MAX_LEN + TAG_EXTRA);

  function automatic logic [31:0] crc_step(input logic [31:0] c_in, input logic [7:0] d);
    logic [31:0] c;
    c = c_in;
    for (int i = 0; i < 8; i++)
      c = (c[0] ^ d[i]) ? ((c >> 1) ^ POLY) : (c >> 1);
    return c;
  endfunction

  logic             in_frame, halted;
  logic [CNT_W-1:0] cnt;
  logic [31:0]      crc;
  logic [3:0][7:0]  sr;
  logic [7:0]       b12;
  logic             ctl_q, tag_q, ovf_q, err_q;

  wire             take    = in_vld && (in_frame || !halted);
  wire             first   = !in_frame;
  wire             end_now = take && in_last;
  wire [CNT_W-1:0] pos     = first ? '0 : cnt;
  wire [CNT_W:0]   len     = {1'b0, pos} + 1'b1;
  wire [31:0]      crc_nxt = crc_step(first ? 32'hFFFFFFFF : crc, in_byte);
  wire [15:0]      etype   = {b12, in_byte};
  wire             at13    = (pos == CNT_W'(13));

  wire ctl  = (!first && ctl_q) || (at13 && etype == 16'h8808);
  wire tag  = (!first && tag_q) || (at13 && etype == 16'h8100);
  wire ovf  = (!first && ovf_q) || fifo_full;
  wire rxe  = (!first && err_q) || in_err;
  wire mism = (crc_nxt != RESIDUE);

  wire crc_bad  = rxe || (mism && !cfg_skip_crc);
  wire aln_bad  = mism && in_odd_bits && !cfg_skip_crc;
  wire len_bad  = !cfg_skip_len && !cfg_allow_short && (len < LIM_MIN);
  wire long_bad = !cfg_skip_len && !cfg_allow_long && (len > (tag ? LIM_TAG : LIM_MAX));
  wire accept   = !(crc_bad || len_bad || long_bad || ovf) && !(ctl && !cfg_keep_ctl);
  wire fwd      = !cfg_strip_fcs || (pos >= CNT_W'(4));

  wire [5:0] set_now = end_now ? {aln_bad, crc_bad, ovf, long_bad, len_bad, accept} : 6'd0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_frame <= 1'b0;
      halted   <= 1'b0;
      cnt      <= '0;
      crc      <= '1;
      sr       <= '0;
      b12      <= '0;
      ctl_q    <= 1'b0;
      tag_q    <= 1'b0;
      ovf_q    <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      if (!in_frame || end_now) halted <= cfg_halt;
      if (take) begin
        in_frame <= !in_last;
        cnt      <= (&pos) ? pos : pos + 1'b1;
        crc      <= crc_nxt;
        sr       <= {sr[2:0], in_byte};
        ovf_q    <= ovf;
        err_q    <= rxe;
        ctl_q    <= ctl;
        tag_q    <= tag;
        if (pos == CNT_W'(12)) b12 <= in_byte;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_vld   <= 1'b0;
      out_byte  <= '0;
      out_last  <= 1'b0;
      out_done  <= 1'b0;
      out_ok    <= 1'b0;
      irq_flags <= '0;
    end else begin
      out_vld   <= take && fwd;
      out_byte  <= cfg_strip_fcs ? sr[3] : in_byte;
      out_last  <= end_now && fwd;
      out_done  <= end_now;
      out_ok    <= end_now && accept;
      irq_flags <= (irq_flags & ~irq_clr) | set_now;
    end
  end

  assign irq       = |(irq_flags & irq_en);
  assign rx_halted = halted;
endmodule

module eth_rx_screen_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       in_vld,
  input logic       in_last,
  input logic       in_frame,
  input logic       rx_halted,
  input logic       out_vld,
  input logic       out_last,
  input logic       out_done,
  input logic       out_ok,
  input logic [5:0] irq_clr,
  input logic [5:0] irq_flags
);
  assert_done_after_last_R11: assert property (@(posedge clk) disable iff (!rst_n)
    out_done |-> $past(in_vld && in_last));
  assert_last_is_valid_R1: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> out_vld);
  assert_halt_blocks_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_halted && !in_frame) |=> (!out_vld && !out_done));
  assert_flags_only_at_done_R12: assert property (@(posedge clk) disable iff (!rst_n)
    ((irq_flags & ~$past(irq_flags)) != 6'd0) |-> out_done);
  assert_clear_works_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !out_done |-> ((irq_flags & $past(irq_clr)) == 6'd0));
  assert_good_only_if_ok_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_done && !out_ok) |-> !(irq_flags[0] && !$past(irq_flags[0])));
endmodule

bind eth_rx_screen eth_rx_screen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_last(in_last), .in_frame(in_frame),
  .rx_halted(rx_halted), .out_vld(out_vld), .out_last(out_last), .out_done(out_done),
  .out_ok(out_ok), .irq_clr(irq_clr), .irq_flags(irq_flags)
);

// File: tb/eth_rx_screen_test.sv
`timescale 1ns/1ps
module eth_rx_screen_test;
  logic clk = 0, rst_n = 0;
  logic in_vld = 0, in_last = 0, in_err = 0, in_odd_bits = 0, fifo_full = 0;
  logic [7:0] in_byte = 0;
  logic cfg_strip_fcs = 0, cfg_skip_crc = 0, cfg_skip_len = 0, cfg_keep_ctl = 0;
  logic cfg_allow_short = 0, cfg_allow_long = 0, cfg_halt = 0;
  logic [5:0] irq_en = 0, irq_clr = 0;
  logic out_vld, out_last, out_done, out_ok, irq, rx_halted;
  logic [7:0] out_byte;
  logic [5:0] irq_flags;

  always #2 clk = ~clk;

  eth_rx_screen uut (.*);

  typedef struct packed {
    logic [11:0] len; logic [15:0] et;
    logic bad; logic rxe; logic odd; logic ovf;
    logic [5:0] cfg; logic ok; logic [5:0] fl;
  } vec_t;
  // cfg = {skip_len, skip_crc, keep_ctl, strip, allow_short, allow_long}
  localparam int NV = 19;
  localparam vec_t VT [NV] = '{
    '{12'd64,   16'h0800, 1'b0,1'b0,1'b0,1'b0, 6'b000000, 1'b1, 6'h01},
    '{12'd63,   16'h0800, 1'b0,1'b0,1'b0,1'b0, 6'b000000, 1'b0, 6'h02},
    '{12'd63,   16'h0800, 1'b0,1'b0,1'b0,1'b0, 6'b000010, 1'b1, 6'h01},
    '{12'd100,  16'h0800, 1'b1,1'b0,1'b0,1'b0, 6'b000000, 1'b0, 6'h10},
    '{12'd1519, 16'h0800, 1'b0,1'b0,1'b0,1'b0, 6'b000000, 1'b0, 6'h04},
    '{12'd1519, 16'h0800, 1'b0,1'b0,1'b0,1'b0, 6'b000001, 1'b1, 6'h01},
    '{12'd1522, 16'h8100, 1'b0,1'b0,1'b0,1'b0, 6'b000000, 1'b1, 6'h01},
    '{12'd1523, 16'h8100, 1'b0,1'b0,1'b0,1'b0, 6'b000000, 1'b0, 6'h04},
    '{12'd64,   16'h8808, 1'b0,1'b0,1'b0,1'b0, 6'b000000, 1'b0, 6'h00},
    '{12'd64,   16'h8808, 1'b0,1'b0,1'b0,1'b0, 6'b001000, 1'b1, 6'h01},
    '{12'd100,  16'h0800, 1'b0,1'b0,1'b0,1'b0, 6'b000100, 1'b1, 6'h01},
    '{12'd100,  16'h0800, 1'b1,1'b0,1'b0,1'b0, 6'b010000, 1'b1, 6'h01},
    '{12'd63,   16'h0800, 1'b0,1'b0,1'b0,1'b0, 6'b100000, 1'b1, 6'h01},
    '{12'd1519, 16'h0800, 1'b0,1'b0,1'b0,1'b0, 6'b100000, 1'b1, 6'h01},
    '{12'd70,   16'h0800, 1'b0,1'b1,1'b0,1'b0, 6'b000000, 1'b0, 6'h10},
    '{12'd100,  16'h0800, 1'b1,1'b0,1'b1,1'b0, 6'b000000, 1'b0, 6'h30},
    '{12'd100,  16'h0800, 1'b0,1'b0,1'b1,1'b0, 6'b000000, 1'b1, 6'h01},
    '{12'd80,   16'h0800, 1'b0,1'b0,1'b0,1'b1, 6'b000000, 1'b0, 6'h08},
    '{12'd100,  16'h0800, 1'b1,1'b0,1'b0,1'b0, 6'b000100, 1'b0, 6'h10}
  };
  localparam string TAGS [NV] = '{"R10","R5","R5","R3","R6","R6","R6","R6","R8","R8",
                                  "R2","R3","R7","R7","R3","R4","R4","R9","R2"};

  int errors = 0, checks = 0;
  logic [7:0] fr [0:1599];
  int ocnt = 0, olast = -1, mism = 0, dones = 0;
  logic got_ok = 0;
  bit finished = 0;

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] crc_step(input logic [31:0] c_in, input logic [7:0] d);
    logic [31:0] c;
    c = c_in;
    for (int i = 0; i < 8; i++)
      c = (c[0] ^ d[i]) ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
    return c;
  endfunction

  always @(negedge clk) begin
    if (out_vld) begin
      if (out_byte !== fr[ocnt]) mism++;
      ocnt++;
      if (out_last) olast = ocnt;
    end
    if (out_done) begin dones++; got_ok = out_ok; end
  end

  task automatic build(input int len, input logic [15:0] et, input logic bad);
    logic [31:0] c;
    c = 32'hFFFFFFFF;
    for (int i = 0; i < len - 4; i++) begin
      if (i == 12) fr[i] = et[15:8];
      else if (i == 13) fr[i] = et[7:0];
      else if (i < 12) fr[i] = 8'(i * 7 + 1);
      else fr[i] = 8'(i * 13 + 5);
      c = crc_step(c, fr[i]);
    end
    c = ~c;
    for (int k = 0; k < 4; k++) fr[len - 4 + k] = c[8*k +: 8];
    if (bad) fr[len - 4] = fr[len - 4] ^ 8'h01;
  endtask

  task automatic send(input int len, input logic rxe, input logic odd, input logic ovf);
    @(negedge clk);
    ocnt = 0; olast = -1; mism = 0; dones = 0; got_ok = 0;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      in_vld = 1; in_byte = fr[i]; in_last = (i == len - 1);
      in_err = rxe && (i == 30); fifo_full = ovf && (i == 20);
      in_odd_bits = odd && (i == len - 1);
    end
    @(negedge clk);
    in_vld = 0; in_last = 0; in_err = 0; fifo_full = 0; in_odd_bits = 0;
    repeat (3) @(negedge clk);
  endtask

  task automatic clear_flags();
    @(negedge clk); irq_clr = '1;
    @(negedge clk); irq_clr = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R14 reset state
    check("R14 out_vld", out_vld, 0);
    check("R14 out_done", out_done, 0);
    check("R14 flags", irq_flags, 0);
    check("R14 irq", irq, 0);
    check("R14 halted", rx_halted, 0);
    rst_n = 1;
    irq_en = '1;
    for (int v = 0; v < NV; v++) begin
      int expn;
      {cfg_skip_len, cfg_skip_crc, cfg_keep_ctl, cfg_strip_fcs, cfg_allow_short, cfg_allow_long} = VT[v].cfg;
      clear_flags();
      build(int'(VT[v].len), VT[v].et, VT[v].bad);
      send(int'(VT[v].len), VT[v].rxe, VT[v].odd, VT[v].ovf);
      expn = cfg_strip_fcs ? int'(VT[v].len) - 4 : int'(VT[v].len);
      check({TAGS[v], " R11 done count"}, dones, 1);
      check({TAGS[v], " verdict"}, got_ok, VT[v].ok);
      check({TAGS[v], " flags"}, irq_flags, VT[v].fl);
      check({TAGS[v], cfg_strip_fcs ? " R2 count" : " R1 count"}, ocnt, expn);
      check({TAGS[v], cfg_strip_fcs ? " R2 last" : " R1 last"}, olast, expn);
      check({TAGS[v], " R1 data"}, mism, 0);
    end
    {cfg_skip_len, cfg_skip_crc, cfg_keep_ctl, cfg_strip_fcs, cfg_allow_short, cfg_allow_long} = '0;

    // R12 masking, sticky, clear
    clear_flags();
    irq_en = 6'b111110;
    build(64, 16'h0800, 0);
    send(64, 0, 0, 0);
    check("R12 flag set", irq_flags, 6'h01);
    check("R12 masked irq", irq, 0);
    @(negedge clk); irq_en = 6'h01;
    @(negedge clk);
    check("R12 irq on", irq, 1);
    repeat (5) @(negedge clk);
    check("R12 sticky", irq_flags, 6'h01);
    irq_clr = 6'h02;
    @(negedge clk); irq_clr = 0;
    check("R12 other clear", irq_flags, 6'h01);
    irq_clr = 6'h01;
    @(negedge clk); irq_clr = 0;
    check("R12 cleared", irq_flags, 6'h00);
    check("R12 irq off", irq, 0);

    // R13 halt while idle
    irq_en = '1;
    cfg_halt = 1;
    @(negedge clk);
    check("R13 halted", rx_halted, 1);
    build(64, 16'h0800, 0);
    send(64, 0, 0, 0);
    check("R13 no bytes", ocnt, 0);
    check("R13 no done", dones, 0);
    check("R13 no flags", irq_flags, 0);
    cfg_halt = 0;
    @(negedge clk); @(negedge clk);
    check("R13 resumed", rx_halted, 0);

    // R13 halt raised mid-frame
    build(100, 16'h0800, 0);
    @(negedge clk);
    ocnt = 0; olast = -1; mism = 0; dones = 0; got_ok = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      in_vld = 1; in_byte = fr[i]; in_last = (i == 99);
      if (i == 40) cfg_halt = 1;
      if (i == 60) check("R13 not halted mid-frame", rx_halted, 0);
    end
    @(negedge clk); in_vld = 0; in_last = 0;
    repeat (2) @(negedge clk);
    check("R13 frame completes", dones, 1);
    check("R13 frame ok", got_ok, 1);
    check("R13 full count", ocnt, 100);
    check("R13 halted after", rx_halted, 1);
    cfg_halt = 0;
    repeat (3) @(negedge clk);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule